// File: doc/BRIEF.md
# Seconds Counter With Alarm Compare

This block is a real-time clock core. It keeps a free-running 32-bit count of seconds and an alarm compare word. Both are reached through a byte-wide register port in which every access moves one byte. A parameterised prescaler divides the input clock into one tick per second. The count advances on that tick only while the run bit of the control register is set.

Software sets the time in two steps. It writes the three upper bytes into a staging area, and this leaves the running count untouched. It then writes the low byte, and that write loads the whole 32-bit word into the counter and restarts the prescaler. The count readback window is live and is not latched. A reader that spans a one-second boundary can detect the carry by reading the low byte again and finding it smaller.

The alarm fires when the enabled alarm sees the count become equal to the compare word. That event sets a status bit. The interrupt output is high while the status bit and the alarm enable are both set. Each new event gives the interrupt a clean low-to-high edge, which suits an edge-triggered interrupt controller.

Top module: `rtc_secs_alarm`

## Requirements
- R1: After reset every register reads 0x00, the counter is stopped, the alarm is disabled and `irq` is low.
- R2: While control bit 7 (run) is 0, the count does not change.
- R3: A write to offset 0x03, 0x04 or 0x05 only stages byte 1, 2 or 3 of a new time and leaves the live count unchanged. A write to offset 0x02 loads the word {staged byte 3, staged byte 2, staged byte 1, written byte} into the counter at that clock edge. Reading offsets 0x02–0x05 returns the staged bytes.
- R4: While run is 1, the count increases by exactly 1 every PRESCALE clocks. The first increment after a load comes PRESCALE clocks after the load edge.
- R5: The count wraps from 0xFFFFFFFF to 0x00000000.
- R6: Offsets 0x06–0x09 show the live count with the least significant byte at 0x06.
- R7: The readback is not latched. A low byte read again after a carry reads lower than the first read, while the upper bytes show the incremented value.
- R8: When control bit 1 (alarm enable) is 1 and the count becomes equal to the alarm word at offsets 0x0A–0x0D (LSB at 0x0A), bit 0 of offset 0x01 (alarm status) sets one clock later and `irq` rises.
- R9: `irq` is the AND of alarm status and alarm enable. Clearing the enable drops `irq` and keeps the status.
- R10: Writing 0x01 with bit 0 at 0 clears the alarm status. Writing it with bit 0 at 1 has no effect.
- R11: While the alarm is disabled, a match between count and alarm word sets no status.
- R12: Control reads back only bits 7 and 1, and the alarm word reads back as written. Reads of offsets 0x0E and 0x0F return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that also feeds the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one byte per asserted cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Alarm interrupt, level high, one rising edge per event |

## Verification
A wrong prescaler phase shows at the live read bytes as an increment one or more clocks early or late after a load. The bench therefore samples the count on every clock of several seconds. A corrupted staging byte or a wrong byte lane appears at the first read after the committing low-byte write. A broken alarm path shows on `irq` and in status bit 0 exactly one clock after the count reaches the compare word.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NBYTES = 4;
  localparam int CNT_W  = 8 * NBYTES;

  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_ASTAT = 4'h1;
  localparam logic [3:0] OFS_WBASE = 4'h2;
  localparam logic [3:0] OFS_RBASE = 4'h6;
  localparam logic [3:0] OFS_ABASE = 4'hA;

  localparam int BIT_RUN  = 7;
  localparam int BIT_AEN  = 1;
  localparam int BIT_STAT = 0;

  function automatic logic [7:0] pick_byte(logic [CNT_W-1:0] w, logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [CNT_W-1:0] next_second(logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(PRESCALE - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           div_q <= '0;
    else if (restart_i)   div_q <= '0;
    else if (run_i) begin
      if (div_q == LAST)  div_q <= '0;
      else                div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = run_i && !restart_i && (div_q == LAST);

  generate
    if (PRESCALE > 1) begin : g_spacing
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count_o <= '0;
    else if (load_i)  count_o <= load_val_i;
    else if (tick_i)  count_o <= next_second(count_o);
  end

  // R4: without a load the count moves by at most one per clock
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] alarm_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             armed_match_o,
  output logic             set_evt_o,
  output logic             status_o,
  output logic             irq_o
);
  logic armed_q;

  assign armed_match_o = en_i && (count_i == alarm_i);
  assign set_evt_o     = armed_match_o && !armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      status_o <= 1'b0;
    end else begin
      armed_q <= armed_match_o;
      if (set_evt_o)   status_o <= 1'b1;
      else if (clr_i)  status_o <= 1'b0;
    end
  end

  assign irq_o = status_o && en_i;

  // R8 / R11: status rises only after an enabled match
  a_r8_status_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(armed_match_o));
  // R10: a clear with no new event leaves status low
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_evt_o) |=> !status_o);
endmodule

// File: rtl/rtc_secs_alarm.sv
module rtc_secs_alarm
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic             run_q, aen_q;
  logic [7:0]       stage_q [NBYTES];
  logic [7:0]       alarm_q [NBYTES];
  logic [CNT_W-1:0] count, alarm_word, load_val;
  logic             load, clr, tick, status, armed_match, set_evt;

  assign load = wr_stb && (addr == OFS_WBASE);
  assign clr  = wr_stb && (addr == OFS_ASTAT) && !wdata[BIT_STAT];

  always_comb begin
    load_val   = {stage_q[3], stage_q[2], stage_q[1], wdata};
    alarm_word = {alarm_q[3], alarm_q[2], alarm_q[1], alarm_q[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      aen_q <= 1'b0;
      for (int i = 0; i < NBYTES; i++) begin
        stage_q[i] <= '0;
        alarm_q[i] <= '0;
      end
    end else if (wr_stb) begin
      if (addr == OFS_CTRL) begin
        run_q <= wdata[BIT_RUN];
        aen_q <= wdata[BIT_AEN];
      end
      for (int i = 0; i < NBYTES; i++) begin
        if (addr == OFS_WBASE + 4'(i)) stage_q[i] <= wdata;
        if (addr == OFS_ABASE + 4'(i)) alarm_q[i] <= wdata;
      end
    end
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .restart_i(load), .tick_o(tick)
  );

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
    .load_val_i(load_val), .count_o(count)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .count_i(count), .alarm_i(alarm_word),
    .en_i(aen_q), .clr_i(clr), .armed_match_o(armed_match),
    .set_evt_o(set_evt), .status_o(status), .irq_o(irq)
  );

  always_comb begin
    rdata = 8'h00;
    if (addr == OFS_CTRL) begin
      rdata[BIT_RUN] = run_q;
      rdata[BIT_AEN] = aen_q;
    end
    if (addr == OFS_ASTAT) rdata[BIT_STAT] = status;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == OFS_WBASE + 4'(i)) rdata = stage_q[i];
      if (addr == OFS_RBASE + 4'(i)) rdata = pick_byte(count, 2'(i));
      if (addr == OFS_ABASE + 4'(i)) rdata = alarm_q[i];
    end
  end

  // R3: the committing write lands the staged word in the counter
  a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R2: a stopped counter without a load holds its value
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load) |=> $stable(count));
  // R9: no interrupt without the alarm enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aen_q) |-> !irq);
endmodule

// File: tb/tb_rtc_secs_alarm.sv
module tb_rtc_secs_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int PS = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_stb = 1'b0, irq;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_secs_alarm #(.PRESCALE(PS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_count(output logic [31:0] c);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(4'(6 + i), b);
      c[8*i +: 8] = b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every offset
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      check("R1 reset read", {24'h0, b}, 32'h0);
    end
    check("R1 irq low", {31'h0, irq}, 32'h0);

    // R2: stopped counter holds
    wr(4'h2, 8'h10);
    repeat (20) @(negedge clk);
    rd_count(c);
    check("R2 stopped hold", c, 32'h10);

    // R3: staging leaves live count, low-byte write commits; R6 lanes
    wr(4'h3, 8'h33); wr(4'h4, 8'h22); wr(4'h5, 8'h11);
    rd_count(c);
    check("R3 staged no effect", c, 32'h10);
    rd(4'h4, b);
    check("R3 staged readback", {24'h0, b}, 32'h22);
    wr(4'h2, 8'h44);
    rd(4'h6, b); check("R6 lane0", {24'h0, b}, 32'h44);
    rd(4'h7, b); check("R6 lane1", {24'h0, b}, 32'h33);
    rd(4'h8, b); check("R6 lane2", {24'h0, b}, 32'h22);
    rd(4'h9, b); check("R6 lane3", {24'h0, b}, 32'h11);

    // R4: rate while running, sampled every clock
    wr(4'h0, 8'h80);
    wr(4'h2, 8'h44);
    for (int n = 0; n < 24; n++) begin
      rd_count(c);
      check("R4 rate", c, 32'h11223344 + 32'(n / PS));
      @(negedge clk);
    end

    // R4: reload mid-second restarts prescaler
    repeat (2) @(negedge clk);
    wr(4'h2, 8'h44);
    for (int n = 0; n < 2 * PS; n++) begin
      rd_count(c);
      check("R4 restart", c, 32'h11223344 + 32'(n / PS));
      @(negedge clk);
    end

    // R5: wrap
    wr(4'h3, 8'hFF); wr(4'h4, 8'hFF); wr(4'h5, 8'hFF); wr(4'h2, 8'hFE);
    repeat (PS) @(negedge clk);
    rd_count(c); check("R5 before wrap", c, 32'hFFFFFFFF);
    repeat (PS) @(negedge clk);
    rd_count(c); check("R5 wrap to zero", c, 32'h0);

    // R7: carry visible between low byte reads
    wr(4'h2, 8'h00); wr(4'h3, 8'h00); wr(4'h4, 8'h00); wr(4'h5, 8'h00);
    wr(4'h2, 8'hFE);
    repeat (2 * PS - 1) @(negedge clk);
    rd(4'h6, b);
    @(negedge clk);
    rd(4'h6, b2);
    check("R7 first low byte", {24'h0, b}, 32'hFF);
    check("R7 reread lower", {31'h0, (b2 < b)}, 32'h1);
    rd(4'h7, b);
    check("R7 upper after carry", {24'h0, b}, 32'h01);

    // R11: disabled alarm ignores a match
    wr(4'hA, 8'h01); wr(4'hB, 8'h01); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
    repeat (6 * PS) @(negedge clk);
    rd(4'h1, b);
    check("R11 no status when disabled", {24'h0, b}, 32'h0);
    check("R11 irq low", {31'h0, irq}, 32'h0);

    // R12: alarm readback, unmapped
    rd(4'hA, b); check("R12 alarm byte0", {24'h0, b}, 32'h01);
    rd(4'hB, b); check("R12 alarm byte1", {24'h0, b}, 32'h01);
    rd(4'hE, b); check("R12 unmapped 0E", {24'h0, b}, 32'h0);
    rd(4'hF, b); check("R12 unmapped 0F", {24'h0, b}, 32'h0);

    // R8: enabled match sets status one clock later
    wr(4'h0, 8'h00);
    wr(4'h3, 8'h01); wr(4'h2, 8'h00);
    wr(4'h0, 8'h82);
    repeat (PS) @(negedge clk);
    rd_count(c); check("R8 count at match", c, 32'h101);
    check("R8 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq raised", {31'h0, irq}, 32'h1);
    rd(4'h1, b); check("R8 status set", {24'h0, b}, 32'h01);

    // R9: gating by enable
    wr(4'h0, 8'h80);
    check("R9 irq drops", {31'h0, irq}, 32'h0);
    rd(4'h1, b); check("R9 status kept", {24'h0, b}, 32'h01);
    wr(4'h0, 8'h82);
    check("R9 irq back", {31'h0, irq}, 32'h1);

    // R10: clear semantics
    wr(4'h1, 8'h01);
    rd(4'h1, b); check("R10 write one ignored", {24'h0, b}, 32'h01);
    wr(4'h1, 8'h00);
    rd(4'h1, b); check("R10 cleared", {24'h0, b}, 32'h0);
    check("R10 irq low", {31'h0, irq}, 32'h0);

    // R12: control shows only run and alarm enable
    wr(4'h0, 8'hFF);
    rd(4'h0, b); check("R12 ctrl bits", {24'h0, b}, 32'h82);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule